// File: doc/BRIEF.md
# Supply-Monitor Reset Generator

This block turns a digital supply-good comparator flag into a system reset. The reset pin is open-drain. The block can only pull it low or let it float. While the supply sits below the trip threshold, reset is pulled. After the supply comes back, the block keeps reset pulled for a programmable number of ticks, then lets it go. The ticks come from a free-running tick strobe. A dip in the supply during that wait throws the partial count away.

A small register bus holds two registers. The first is a 2-bit delay-code register, kept across supply events. It picks one of four release delays, each a power of two in ticks. The second is a read-only status register. It reports three conditions: the supply is below the trip point, the supply has not yet passed the power-on level, and reset is currently pulled. Both comparator flags pass through two-flop synchronizers before any logic uses them.

Top module: `psu_reset_gen`

## Requirements
- R1: After `rst_n` is released, the block pulls reset (`rst_pull_o`=1), the delay register reads 3, and the status register reads 8'h07 while both comparator inputs are low.
- R2: While the synchronized `supply_ok_i` is low, `rst_pull_o` stays 1 however many `tick_i` pulses arrive. Ticks seen in this state do not count toward the release delay.
- R3: Once the synchronized supply is good, `rst_pull_o` falls on the clock edge that samples the N-th `tick_i` pulse. With the default parameters, N = 2 << code, so codes 0, 1, 2 and 3 give 2, 4, 8 and 16 ticks.
- R4: If the supply drops during the release wait, the tick count is cleared. After recovery, a full N ticks is needed again.
- R5: While reset is released, a fall of `supply_ok_i` makes `rst_pull_o` 1 on the third rising clock edge after the change. It is still 0 after the second edge.
- R6: The status register at address 8'hF9 has three live bits. Bit 0 is 1 while the synchronized `por_ok_i` is low. Bit 1 is 1 while the synchronized supply is below the trip point. Bit 2 is 1 while reset is pulled. Bits 7:3 read 0.
- R7: The delay register at address 8'hF1 stores `bus_wdata_i[1:0]` on a write. Bits 7:2 always read 0.
- R8: A write to any address other than 8'hF1 changes no register. A read of any address other than 8'hF1 or 8'hF9 returns 0.
- R9: Status bit 2 always equals `rst_pull_o`. No output ever drives the reset pin high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| supply_ok_i | input | 1 | Asynchronous comparator flag: supply above trip point |
| por_ok_i | input | 1 | Asynchronous comparator flag: supply above power-on level |
| tick_i | input | 1 | One-cycle timebase strobe for the release delay |
| bus_sel_i | input | 1 | Register bus select |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the same cycle as a read select |
| rst_pull_o | output | 1 | 1 = pull reset pin low, 0 = release (float) |

## Verification
The hardest case to reach from the ports is a supply dip that lands partway through a release count. The drop only takes effect after the synchronizer, so a tick that arrives in that window must not push the count to completion. The bench drives inputs on falling edges and counts the synchronizer edges exactly. It lets a known number of ticks accumulate, pulls the supply, waits until the hold state is certain, and restores it. It then proves that one tick short of the full count still leaves reset pulled. Each delay code is also measured at its exact edge, one tick short and on the last tick.

// File: rtl/psu_reset_pkg.sv
package psu_reset_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } rst_state_e;

    localparam int STAT_POR_BIT = 0;
    localparam int STAT_LOW_BIT = 1;
    localparam int STAT_RST_BIT = 2;

endpackage

// File: rtl/psu_flag_sync.sv
module psu_flag_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.pipe[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.pipe[i] = s_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_o = s_q.pipe[STAGES-1];
endmodule

// File: rtl/psu_release_timer.sv
module psu_release_timer
    import psu_reset_pkg::*;
#(
    parameter int SHIFT0 = 1,
    parameter int CODE_W = 2,
    localparam int CNT_W = SHIFT0 + (1 << CODE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sup_ok,
    input  logic              tick_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              pull_o
);
    typedef struct packed {
        rst_state_e       state;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_inc;

    assign limit   = CNT_W'(1) << (SHIFT0 + int'(code_i));
    assign cnt_inc = t_q.cnt + CNT_W'(1);

    always_comb begin
        t_d = t_q;
        unique case (t_q.state)
            ST_HOLD: begin
                t_d.cnt = '0;
                if (sup_ok) t_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (!sup_ok) begin
                    t_d.state = ST_HOLD;
                    t_d.cnt   = '0;
                end else if (tick_i) begin
                    if (cnt_inc >= limit) begin
                        t_d.state = ST_RUN;
                        t_d.cnt   = '0;
                    end else begin
                        t_d.cnt = cnt_inc;
                    end
                end
            end
            ST_RUN: begin
                t_d.cnt = '0;
                if (!sup_ok) t_d.state = ST_HOLD;
            end
            default: begin
                t_d.state = ST_HOLD;
                t_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.state <= ST_HOLD;
            t_q.cnt   <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign pull_o = (t_q.state != ST_RUN);

    // R2: a low supply never leads into the released state
    assert_low_keeps_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_ok |=> t_q.state != ST_RUN);

    // R3: release only happens on a sampled tick with good supply
    assert_release_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pull_o) |-> ($past(tick_i) && $past(sup_ok)));

    // R4: a dip while waiting clears the count
    assert_dip_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.state == ST_WAIT && !sup_ok) |=> (t_q.state == ST_HOLD && t_q.cnt == '0));
endmodule

// File: rtl/psu_reg_port.sv
module psu_reg_port
    import psu_reset_pkg::*;
#(
    parameter logic [7:0] DLY_ADDR  = 8'hF1,
    parameter logic [7:0] STAT_ADDR = 8'hF9,
    parameter int         CODE_W    = 2,
    parameter logic [CODE_W-1:0] CODE_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [7:0]        addr_i,
    input  logic [CODE_W-1:0] wcode_i,
    input  logic              st_por_i,
    input  logic              st_low_i,
    input  logic              st_rst_i,
    output logic [7:0]        rdata_o,
    output logic [CODE_W-1:0] code_o
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_dly;
    logic  [7:0] status;

    assign wr_dly = sel_i && wr_i && (addr_i == DLY_ADDR);

    always_comb begin
        r_d = r_q;
        if (wr_dly) r_d.code = wcode_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q.code <= CODE_RST;
        else        r_q <= r_d;
    end

    always_comb begin
        status = '0;
        status[STAT_POR_BIT] = st_por_i;
        status[STAT_LOW_BIT] = st_low_i;
        status[STAT_RST_BIT] = st_rst_i;
        rdata_o = '0;
        if (sel_i && !wr_i) begin
            if (addr_i == DLY_ADDR)       rdata_o = 8'(r_q.code);
            else if (addr_i == STAT_ADDR) rdata_o = status;
        end
    end

    assign code_o = r_q.code;

    // R7: a delay write is stored
    assert_delay_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dly |=> code_o == $past(wcode_i));

    // R8: other writes leave the delay code alone
    assert_other_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && wr_i && addr_i != DLY_ADDR) |=> $stable(code_o));

    // R6: unused status bits stay zero
    assert_status_unused_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !wr_i && addr_i == STAT_ADDR) |-> rdata_o[7:3] == 5'd0);
endmodule

// File: rtl/psu_reset_gen.sv
module psu_reset_gen #(
    parameter logic [7:0] DLY_ADDR  = 8'hF1,
    parameter logic [7:0] STAT_ADDR = 8'hF9,
    parameter int         SHIFT0    = 1,
    parameter int         SYNC_STG  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok_i,
    input  logic       por_ok_i,
    input  logic       tick_i,
    input  logic       bus_sel_i,
    input  logic       bus_wr_i,
    input  logic [7:0] bus_addr_i,
    input  logic [7:0] bus_wdata_i,
    output logic [7:0] bus_rdata_o,
    output logic       rst_pull_o
);
    localparam int CODE_W = 2;
    localparam int NFLAG  = 2;

    logic [NFLAG-1:0]  flags_sync;
    logic [CODE_W-1:0] code;
    logic              pull;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata_i[7:CODE_W];

    psu_flag_sync #(.WIDTH(NFLAG), .STAGES(SYNC_STG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({por_ok_i, supply_ok_i}),
        .sync_o  (flags_sync)
    );

    psu_release_timer #(.SHIFT0(SHIFT0), .CODE_W(CODE_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .sup_ok (flags_sync[0]),
        .tick_i (tick_i),
        .code_i (code),
        .pull_o (pull)
    );

    psu_reg_port #(.DLY_ADDR(DLY_ADDR), .STAT_ADDR(STAT_ADDR), .CODE_W(CODE_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (bus_sel_i),
        .wr_i     (bus_wr_i),
        .addr_i   (bus_addr_i),
        .wcode_i  (bus_wdata_i[CODE_W-1:0]),
        .st_por_i (~flags_sync[1]),
        .st_low_i (~flags_sync[0]),
        .st_rst_i (pull),
        .rdata_o  (bus_rdata_o),
        .code_o   (code)
    );

    assign rst_pull_o = pull;

    // R1: leaving block reset, reset is pulled and the default code is loaded
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rst_pull_o && code == '1));
endmodule

// File: tb/psu_reset_gen_test.sv
`timescale 1ns/1ps
module psu_reset_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b0;
    logic       por_ok = 1'b0;
    logic       tick = 1'b0;
    logic       sel = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       pull;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    localparam logic [7:0] A_DLY  = 8'hF1;
    localparam logic [7:0] A_STAT = 8'hF9;

    always #2 clk = ~clk;

    psu_reset_gen uut (
        .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .por_ok_i(por_ok),
        .tick_i(tick), .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .rst_pull_o(pull)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic give_ticks(int n);
        repeat (n) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic set_supply(logic v);
        @(negedge clk) supply_ok = v;
        wait_clk(3);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(1);
        chk("R1 pull after reset", 8'(pull), 8'h01);
        bus_read(A_DLY, d);  chk("R1 delay default", d, 8'h03);
        bus_read(A_STAT, d); chk("R1 status after reset", d, 8'h07);
    endtask

    task automatic t_hold_ticks;
        logic [7:0] d;
        @(negedge clk) por_ok = 1'b1;
        give_ticks(20);
        chk("R2 pull while supply low", 8'(pull), 8'h01);
        bus_read(A_STAT, d); chk("R6 status low supply", d, 8'h06);
    endtask

    task automatic t_release_default;
        logic [7:0] d;
        set_supply(1'b1);
        bus_read(A_STAT, d); chk("R9 status waiting", d, 8'h04);
        give_ticks(15);
        chk("R2 ticks in hold not counted, R3 one short", 8'(pull), 8'h01);
        give_ticks(1);
        chk("R3 release on 16th tick", 8'(pull), 8'h00);
        bus_read(A_STAT, d); chk("R9 status released", d, 8'h00);
    endtask

    task automatic t_drop;
        logic [7:0] d;
        @(negedge clk) supply_ok = 1'b0;
        wait_clk(2);
        chk("R5 pull still low after two edges", 8'(pull), 8'h00);
        wait_clk(1);
        chk("R5 pull on third edge", 8'(pull), 8'h01);
        bus_read(A_STAT, d); chk("R6 status after drop", d, 8'h06);
    endtask

    task automatic t_codes;
        logic [7:0] d;
        bus_write(A_DLY, 8'hFC);
        bus_read(A_DLY, d); chk("R7 code 0 upper bits zero", d, 8'h00);
        set_supply(1'b1);
        give_ticks(1); chk("R3 code0 one short", 8'(pull), 8'h01);
        give_ticks(1); chk("R3 code0 release", 8'(pull), 8'h00);
        set_supply(1'b0);
        bus_write(A_DLY, 8'h02);
        bus_read(A_DLY, d); chk("R7 code 2 readback", d, 8'h02);
        set_supply(1'b1);
        give_ticks(7); chk("R3 code2 one short", 8'(pull), 8'h01);
        give_ticks(1); chk("R3 code2 release", 8'(pull), 8'h00);
        set_supply(1'b0);
    endtask

    task automatic t_restart;
        bus_write(A_DLY, 8'h01);
        set_supply(1'b1);
        give_ticks(3);
        chk("R4 partial count", 8'(pull), 8'h01);
        set_supply(1'b0);
        set_supply(1'b1);
        give_ticks(3); chk("R4 count restarted", 8'(pull), 8'h01);
        give_ticks(1); chk("R4 full count releases", 8'(pull), 8'h00);
    endtask

    task automatic t_other_addr;
        logic [7:0] d;
        bus_write(8'hF0, 8'h00);
        bus_write(A_STAT, 8'h03);
        bus_read(A_DLY, d);  chk("R8 delay untouched", d, 8'h01);
        bus_read(8'hF0, d);  chk("R8 unmapped read zero", d, 8'h00);
        bus_read(A_STAT, d); chk("R8 status unchanged by write", d, 8'h00);
    endtask

    task automatic t_por_bit;
        logic [7:0] d;
        @(negedge clk) por_ok = 1'b0;
        wait_clk(3);
        bus_read(A_STAT, d); chk("R6 power-on bit alone", d, 8'h01);
        chk("R9 reset stays released", 8'(pull), 8'h00);
        @(negedge clk) por_ok = 1'b1;
        wait_clk(3);
    endtask

    initial begin
        t_reset();
        t_hold_ticks();
        t_release_default();
        t_drop();
        t_codes();
        t_restart();
        t_other_addr();
        t_por_bit();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule